// File: doc/BRIEF.md
# Interrupt Cause Register

This block collects interrupt-causing events from the transmit, receive and link logic of a network controller into one memory-mapped cause register. Each event arrives as a one-cycle pulse and sets a sticky bit. The link indication arrives as a level, and every change of that level, in either direction, sets its own bit. Software acknowledges events in one of two ways. A read of the register returns the pending causes and then clears all of them. A write clears only the bits written as 1.

An enable mask comes in from outside the block. The single interrupt output is a registered level. It is high whenever some cause bit that is set also has its enable bit set. Register accesses use a plain strobe port. Read data is combinational in the cycle of the read strobe and is zero when no read of the cause address is in progress.

Top module: `irq_cause_reg`

## Requirements
- R1: A one-cycle pulse on an event input sets its cause bit at that clock edge, and the bit stays set until it is cleared. The bit positions are: bit 0 `tx_done`, bit 1 `txq_empty`, bit 3 `rx_seq_err`, bit 4 `rx_low_desc`, bit 6 `rx_overrun`.
- R2: With `reg_rd` high and `reg_addr` equal to `CAUSE_ADDR` (default 12'h040), `reg_rdata` in that cycle carries the cause bits in positions 6:0. After that clock edge every cause bit is 0, unless R7 applies.
- R3: With `reg_wr` high at `CAUSE_ADDR`, each cause bit whose `reg_wdata` bit is 1 is cleared at the clock edge. Each bit written as 0 keeps its value.
- R4: Bit 2 sets whenever `link_up` differs from its value sampled at the previous clock edge, on rising and on falling changes alike. The previous value is 0 after reset, so a link that is already high when reset ends also sets bit 2.
- R5: Bit 5 and bits 31:7 of `reg_rdata` always read 0. No event and no write can set them.
- R6: While `rst_n` is low at a clock edge, every cause bit and `irq_out` become 0.
- R7: When an event (including a link change) occurs in the same cycle as a read or a write-1 clear of its bit, the set wins, and the bit reads 1 at the next access.
- R8: `irq_out` is a register. At each clock edge it takes the OR over all bits of the cause bits ANDed with `irq_en` (bit i enables cause bit i). It therefore follows a change of cause or mask one cycle later.
- R9: A read at any address other than `CAUSE_ADDR` returns 0 and does not clear anything. A write at any other address does not change the cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (12) | Register address |
| reg_rd | input | 1 | Read strobe; a read of the cause address clears all causes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data; a 1 clears the matching cause bit |
| reg_rdata | output | DATA_W (32) | Read data, valid while `reg_rd` is high |
| tx_done | input | 1 | Pulse: a transmit descriptor has been written back |
| txq_empty | input | 1 | Pulse: the transmit queue has run empty |
| rx_seq_err | input | 1 | Pulse: a receive delimiter sequence error |
| rx_low_desc | input | 1 | Pulse: free receive descriptors have reached the minimum threshold |
| rx_overrun | input | 1 | Pulse: the receive data FIFO has overrun |
| link_up | input | 1 | Link status level |
| irq_en | input | CAUSE_W (7) | Per-bit interrupt enable mask |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach is a collision: an event pulse, or a link transition, lands in exactly the cycle in which software clears the same bit. A test that only reads back results cannot show whether the event was lost, because the read itself erases the evidence. The stimulus therefore issues a read and a write-1 clear in the very cycle of a matching event, and then reads again. Long stretches of mixed accesses are also driven, with random addresses, data, sparse events, link toggles and mask values. Every cycle of these stretches is compared against a behavioural model, so the collision also arises with other bits set and with partial write masks.

// File: rtl/irq_cause_pkg.sv
// Package irq_cause_pkg
// Shared widths and cause-bit positions for the interrupt cause register.
// Assumes bit positions are fixed by software that decodes the register.
package irq_cause_pkg;
    localparam int CAUSE_W      = 7;
    localparam int B_TX_DONE    = 0;
    localparam int B_TXQ_EMPTY  = 1;
    localparam int B_LINK       = 2;
    localparam int B_RX_SEQ     = 3;
    localparam int B_RX_LOWDESC = 4;
    localparam int B_RSVD       = 5;
    localparam int B_RX_OVR     = 6;
    // Bits that hold state; bit 5 is reserved and tied to zero.
    localparam logic [CAUSE_W-1:0] IMPL_MASK = 7'b101_1111;
endpackage

// File: rtl/link_change_det.sv
// Module link_change_det
// Registers the link level once and flags any difference between the
// present level and the registered one. Assumes link_in is already
// synchronous to clk. The previous value resets to 0 (link down).
module link_change_det (
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    output logic link_prev,
    output logic changed
);
    // Hold the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) link_prev <= 1'b0;
        else        link_prev <= link_in;
    end

    // A difference in either direction is a change.
    always_comb changed = link_in ^ link_prev;
endmodule

// File: rtl/cause_bank.sv
// Module cause_bank
// A row of sticky cause bits. Each implemented bit sets on set[i] and
// clears on clr[i]. Set has priority over clear. Bits not marked in IMPL
// are constant zero and hold no state. Assumes a synchronous active-low reset.
module cause_bank #(
    parameter int           W    = 7,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cause
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            // Sticky bit: set wins over clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)      cause[i] <= 1'b0;
                else if (set[i]) cause[i] <= 1'b1;
                else if (clr[i]) cause[i] <= 1'b0;
            end
        end else begin : g_rsvd
            // Reserved position: always zero.
            assign cause[i] = 1'b0;
        end
    end

    logic unused_rsvd_inputs;
    assign unused_rsvd_inputs = ^(set & ~IMPL) ^ ^(clr & ~IMPL);
endmodule

// File: rtl/irq_gen.sv
// Module irq_gen
// Produces the registered interrupt level from cause bits and enables.
// Assumes cause and mask are synchronous to clk; the output has one cycle
// of latency and no combinational path.
module irq_gen #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause,
    input  logic [W-1:0] mask,
    output logic         irq
);
    // Register the OR over enabled causes.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(cause & mask);
    end
endmodule

// File: rtl/irq_cause_reg.sv
// Module irq_cause_reg (top)
// Memory-mapped interrupt cause register. It latches event pulses and link
// changes into sticky bits. A read at CAUSE_ADDR clears all bits, and a
// write clears the bits written as 1. Events win over clears in the same
// cycle. Assumes single-cycle strobes, all inputs synchronous to clk, and
// a mask supplied from outside.
module irq_cause_reg
    import irq_cause_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 12'h040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               tx_done,
    input  logic               txq_empty,
    input  logic               rx_seq_err,
    input  logic               rx_low_desc,
    input  logic               rx_overrun,
    input  logic               link_up,
    input  logic [CAUSE_W-1:0] irq_en,
    output logic               irq_out
);
    localparam int PAD_W = DATA_W - CAUSE_W;

    logic               hit;
    logic               rd_hit;
    logic               wr_hit;
    logic               link_prev;
    logic               link_chg;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;
    logic [CAUSE_W-1:0] cause_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CAUSE_W];

    // Address decode for the single register.
    always_comb begin
        hit    = (reg_addr == CAUSE_ADDR);
        rd_hit = reg_rd & hit;
        wr_hit = reg_wr & hit;
    end

    link_change_det u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_in   (link_up),
        .link_prev (link_prev),
        .changed   (link_chg)
    );

    // Collect the set requests into their bit positions.
    always_comb begin
        set_vec               = '0;
        set_vec[B_TX_DONE]    = tx_done;
        set_vec[B_TXQ_EMPTY]  = txq_empty;
        set_vec[B_LINK]       = link_chg;
        set_vec[B_RX_SEQ]     = rx_seq_err;
        set_vec[B_RX_LOWDESC] = rx_low_desc;
        set_vec[B_RX_OVR]     = rx_overrun;
    end

    // Clear requests: a read clears everything, a write clears the 1s.
    always_comb begin
        clr_vec = '0;
        if (rd_hit) clr_vec = '1;
        if (wr_hit) clr_vec = clr_vec | reg_wdata[CAUSE_W-1:0];
    end

    cause_bank #(
        .W    (CAUSE_W),
        .IMPL (IMPL_MASK)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (clr_vec),
        .cause (cause_q)
    );

    irq_gen #(
        .W (CAUSE_W)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause_q),
        .mask  (irq_en),
        .irq   (irq_out)
    );

    // Read data: cause bits during a read hit, zero otherwise.
    always_comb begin
        if (rd_hit) reg_rdata = {{PAD_W{1'b0}}, cause_q};
        else        reg_rdata = '0;
    end
endmodule

// File: rtl/irq_cause_chk.sv
// Module irq_cause_chk
// Property checker for irq_cause_reg, attached by bind. It observes the
// ports and the internal set vector, cause bits and previous link level.
module irq_cause_chk #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                CW         = 7,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 12'h040
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [CW-1:0]     wdata_lo,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              link_up,
    input logic              link_prev,
    input logic [CW-1:0]     irq_en,
    input logic              irq_out,
    input logic [CW-1:0]     set_vec,
    input logic [CW-1:0]     cause
);
    logic hit;
    logic quiet;
    assign hit   = (reg_addr == CAUSE_ADDR);
    assign quiet = (set_vec == '0);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && hit) && !(reg_wr && hit) |=> ((cause & $past(cause)) == $past(cause))); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && hit && quiet |=> (cause == '0)); // R2

    AST_W1C_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && hit && !reg_rd && quiet |=> (cause == ($past(cause) & ~$past(wdata_lo)))); // R3

    AST_LINK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != link_prev) |=> cause[2]); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] == 1'b0) && (reg_rdata[DATA_W-1:7] == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec))); // R7

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(cause & irq_en)))); // R8

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) && !hit && quiet |=> $stable(cause)); // R9
endmodule

bind irq_cause_reg irq_cause_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CW         (irq_cause_pkg::CAUSE_W),
    .CAUSE_ADDR (CAUSE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .wdata_lo  (reg_wdata[irq_cause_pkg::CAUSE_W-1:0]),
    .reg_rdata (reg_rdata),
    .link_up   (link_up),
    .link_prev (link_prev),
    .irq_en    (irq_en),
    .irq_out   (irq_out),
    .set_vec   (set_vec),
    .cause     (cause_q)
);

// File: tb/irq_cause_reg_bench.sv
// Bench for irq_cause_reg: directed cases plus random traffic, with a
// behavioural model compared on every clock.
module irq_cause_reg_bench;
    localparam logic [11:0] CA    = 12'h040;
    localparam logic [11:0] OTHER = 12'h044;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] addr;
    logic        rd, wr;
    logic [31:0] wdata;
    logic [6:0]  evts;
    logic        link;
    logic [6:0]  mask;
    logic [31:0] rdata;
    logic        irq;

    int    vectors = 0;
    int    fails   = 0;
    string cur_tag = "R6";

    // Model state
    logic [31:0] m_cause = '0;
    logic        m_prev  = 1'b0;
    logic        m_irq   = 1'b0;

    always #5 clk = ~clk;

    irq_cause_reg u_irq_cause_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (addr),
        .reg_rd      (rd),
        .reg_wr      (wr),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .tx_done     (evts[0]),
        .txq_empty   (evts[1]),
        .rx_seq_err  (evts[3]),
        .rx_low_desc (evts[4]),
        .rx_overrun  (evts[6]),
        .link_up     (link),
        .irq_en      (mask),
        .irq_out     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of the cause register, updated at every edge.
    always @(posedge clk) begin
        logic [31:0] clrv;
        logic [31:0] setv;
        if (!rst_n) begin
            m_cause = '0;
            m_prev  = 1'b0;
            m_irq   = 1'b0;
        end else begin
            m_irq = ((m_cause[6:0] & mask) != 7'd0);
            clrv = '0;
            if (rd && addr == CA) clrv = '1;
            if (wr && addr == CA) clrv = clrv | wdata;
            setv = {25'd0, evts[6], 1'b0, evts[4], evts[3], (link != m_prev), evts[1], evts[0]};
            m_cause = ((m_cause & ~clrv) | setv) & 32'h0000_005F;
            m_prev  = link;
        end
    end

    // Per-cycle comparison, away from both clock edges.
    always @(negedge clk) begin
        #3;
        check({cur_tag, " rdata"}, rdata, (rd && addr == CA) ? m_cause : 32'd0);
        check({cur_tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    end

    task automatic step(input logic r, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [6:0] e);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d; evts = e;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, CA, 32'd0, 7'd0);
    endtask

    // Read at the cause address and check the value in that cycle.
    task automatic rd_expect(input string tag, input logic [31:0] exp);
        step(1'b1, 1'b0, CA, 32'd0, 7'd0);
        #2;
        check(tag, rdata, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        rst_n = 1'b0; rd = 0; wr = 0; addr = CA; wdata = '0; evts = '0;
        link = 1'b0; mask = '0;
        repeat (3) @(negedge clk);
        #2;
        check("R6 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        rd_expect("R6 reset cause", 32'd0);

        // R1: each event once, then bits stay set.
        cur_tag = "R1";
        step(0, 0, CA, 0, 7'b000_0001);
        step(0, 0, CA, 0, 7'b000_0010);
        step(0, 0, CA, 0, 7'b000_1000);
        step(0, 0, CA, 0, 7'b001_0000);
        step(0, 0, CA, 0, 7'b100_0000);
        idle(); idle();
        // R2: read returns then clears.
        cur_tag = "R2";
        rd_expect("R1 sticky causes", 32'h0000_005B);
        rd_expect("R2 cleared by read", 32'd0);

        // R4: both link edges.
        cur_tag = "R4";
        @(negedge clk); link = 1'b1; rd = 0; wr = 0; evts = '0;
        idle();
        rd_expect("R4 rising link", 32'h0000_0004);
        @(negedge clk); link = 1'b0; rd = 0;
        idle();
        rd_expect("R4 falling link", 32'h0000_0004);
        rd_expect("R4 cleared", 32'd0);

        // R3: write-1 clears only selected bits.
        cur_tag = "R3";
        step(0, 0, CA, 0, 7'b101_1011);
        step(0, 1, CA, 32'h0000_0009, 7'd0);
        rd_expect("R3 partial clear", 32'h0000_0052);

        // R5: reserved bits cannot be set.
        cur_tag = "R5";
        step(0, 0, CA, 0, 7'b111_1111);
        step(0, 1, CA, 32'hFFFF_FF80, 7'd0);
        rd_expect("R5 reserved zero", 32'h0000_005B);
        step(0, 1, CA, 32'hFFFF_FFFF, 7'd0);
        rd_expect("R5 after full clear", 32'd0);

        // R7: set beats read and write clear in the same cycle.
        cur_tag = "R7";
        step(1, 0, CA, 0, 7'b000_0001);
        #2; check("R7 read cycle value", rdata, 32'd0);
        rd_expect("R7 set over read", 32'h0000_0001);
        step(0, 0, CA, 0, 7'b000_0010);
        step(0, 1, CA, 32'h0000_0002, 7'b000_0010);
        rd_expect("R7 set over write", 32'h0000_0002);
        @(negedge clk); link = 1'b1; rd = 1; wr = 0; addr = CA; evts = '0;
        rd_expect("R7 link over read", 32'h0000_0004);
        @(negedge clk); link = 1'b0; rd = 0; idle();
        rd_expect("R7 link clear", 32'h0000_0004);

        // R9: other addresses have no effect.
        cur_tag = "R9";
        step(0, 0, CA, 0, 7'b100_0000);
        step(1, 0, OTHER, 0, 7'd0);
        #2; check("R9 other read data", rdata, 32'd0);
        step(0, 1, OTHER, 32'hFFFF_FFFF, 7'd0);
        rd_expect("R9 causes kept", 32'h0000_0040);

        // R8: registered masked interrupt.
        cur_tag = "R8";
        step(0, 0, CA, 0, 7'b000_0001);
        idle();
        #2; check("R8 masked off", {31'd0, irq}, 32'd0);
        @(negedge clk); mask = 7'b000_0001;
        #2; check("R8 before edge", {31'd0, irq}, 32'd0);
        idle();
        #2; check("R8 enabled", {31'd0, irq}, 32'd1);
        rd_expect("R8 read value", 32'h0000_0001);
        #0; check("R8 irq during read", {31'd0, irq}, 32'd1);
        idle();
        #2; check("R8 one cycle after clear", {31'd0, irq}, 32'd1);
        idle();
        #2; check("R8 dropped", {31'd0, irq}, 32'd0);
        mask = '0;

        // Mixed random traffic checked against the model every cycle.
        cur_tag = "R3 random";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            @(negedge clk);
            rd    = (rv[3:0] == 4'd0);
            wr    = (rv[7:4] == 4'd1);
            addr  = rv[8] ? OTHER : CA;
            if (rv[11:9] != 3'd0) addr = CA;
            wdata = $urandom;
            evts  = 7'($urandom) & 7'($urandom) & 7'($urandom);
            if (rv[15:12] == 4'd0) link = ~link;
            if (rv[19:16] == 4'd0) mask = 7'($urandom);
        end
        idle(); idle();
        finish_run();
    end
endmodule